// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block steers a 16-bit processor with a 24-bit program counter to its handlers. When reset is released, and whenever one of seven interrupt lines is honoured, it reads a two-word entry from a vector table at the very bottom of memory. It assembles a 24-bit jump target from those two words and presents it on a program-counter load port. Index 0 of the table holds the reset target. Indices 1 to 7 belong to the interrupt lines.

The processor signals each instruction boundary. Pending requests are examined only on such a cycle, only while the global enable flag is set, and only while the sequencer is idle. The enable flag lives inside the block. The processor sets or clears it with two strobes, and the block clears it by itself whenever it takes a vector. Memory is read through a single-word request port that waits for a ready handshake, so any number of wait states is tolerated. The block is busy from the moment a fetch starts until the target has been loaded. The processor stalls while the block is busy.

Top module: `vector_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the block reports busy. It requests memory at word address 0. pc_load, irq_ack and ien are all 0.
- R2: After reset, the block fetches table index 0 without any boundary or enable. It loads that target with irq_ack all zero, then goes idle.
- R3: Table index k uses word 2k and word 2k+1. The low byte of word 2k gives target bits 23:16, and its upper byte is ignored. Word 2k+1 gives target bits 15:0. Interrupt line n (bit n-1 of irq_req, n = 1..7) uses index n.
- R4: When several lines are active at a taken boundary, the lowest-numbered line is serviced.
- R5: A request is not taken if insn_boundary is low, if ien is low, or while busy. In those cases the block stays idle with mem_req low.
- R6: ien resets to 0. ien_set sets it and ien_clr clears it, with clear winning. Taking a vector clears it in the following cycle, whatever strobe is present.
- R7: Each read holds mem_req and mem_addr stable until mem_ready. With w wait states per read, pc_load is high exactly 2w+3 cycles after the boundary cycle on which the vector was taken.
- R8: pc_load is a single-cycle pulse. In that cycle irq_ack has exactly the serviced line's bit set (bit n-1), and irq_ack is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Interrupt request lines, bit n-1 is line n |
| insn_boundary | input | 1 | Processor is between instructions |
| ien_set | input | 1 | Strobe: set global interrupt enable |
| ien_clr | input | 1 | Strobe: clear global interrupt enable |
| ien | output | 1 | Current global interrupt enable |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Word address of the read |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read completes this cycle |
| busy | output | 1 | Fetch in progress, processor must stall |
| pc_load | output | 1 | Load pc_value into the program counter |
| pc_value | output | 24 | Assembled vector target |
| irq_ack | output | 7 | Acknowledge for the serviced line |

## Verification
The vector is taken on the clock edge that samples the boundary. Each read then spends w+1 cycles, and one more cycle drives the load, so pc_load is due 2w+3 cycles after the boundary cycle. After reset release it is due 2w+2 cycles later. The bench drives inputs on falling edges and counts falling edges until pc_load, and it compares that count with the formula for wait states 0 to 3 on every line. The enable is checked one cycle after the take, and idle state one cycle after the load. An ignored request is checked by watching mem_req and busy stay low for several cycles.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int NUM_IRQ = 7;
    localparam int IDX_W   = $clog2(NUM_IRQ + 1);
    localparam int HI_W    = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
    } target_t;

    // word address of one half of a table entry
    function automatic logic [ADDR_W-1:0] entry_addr(input logic [IDX_W-1:0] idx,
                                                     input logic odd);
        return ADDR_W'({idx, odd});
    endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import vecseq_pkg::*;
(
    input  logic [NUM_IRQ-1:0] req,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        // scan downward so the lowest active line is written last
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i + 1);
        end
    end
    assign valid = |req;
endmodule

// File: rtl/vec_fetch_fsm.sv
module vec_fetch_fsm
    import vecseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              load,
    output target_t           target,
    output logic [IDX_W-1:0]  cur_idx
);
    seq_state_e state_q;
    target_t    tgt_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RD_HI;
            idx_q   <= '0;
            tgt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RD_HI;
                    idx_q   <= start_idx;
                end
                ST_RD_HI: if (mem_ready) begin
                    tgt_q.hi <= mem_rdata[HI_W-1:0];
                    state_q  <= ST_RD_LO;
                end
                ST_RD_LO: if (mem_ready) begin
                    tgt_q.lo <= mem_rdata;
                    state_q  <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
    assign mem_addr = entry_addr(idx_q, state_q == ST_RD_LO);
    assign busy     = state_q != ST_IDLE;
    assign load     = state_q == ST_LOAD;
    assign target   = tgt_q;
    assign cur_idx  = idx_q;
endmodule

// File: rtl/vector_sequencer.sv
module vector_sequencer
    import vecseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               insn_boundary,
    input  logic               ien_set,
    input  logic               ien_clr,
    output logic               ien,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               busy,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_value,
    output logic [NUM_IRQ-1:0] irq_ack
);
    logic             arb_valid;
    logic [IDX_W-1:0] arb_idx;
    logic [IDX_W-1:0] cur_idx;
    logic             take;
    logic             ien_q;
    target_t          target;

    irq_arbiter u_arb (
        .req   (irq_req),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    assign take = !busy && insn_boundary && ien_q && arb_valid;

    always_ff @(posedge clk) begin
        if (rst)                    ien_q <= 1'b0;
        else if (take || ien_clr)   ien_q <= 1'b0;
        else if (ien_set)           ien_q <= 1'b1;
    end
    assign ien = ien_q;

    vec_fetch_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (take),
        .start_idx (arb_idx),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .load      (pc_load),
        .target    (target),
        .cur_idx   (cur_idx)
    );

    assign pc_value = target;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ack
        assign irq_ack[g] = pc_load && (cur_idx == IDX_W'(g + 1));
    end
endmodule

// File: rtl/vector_sequencer_chk.sv
module vector_sequencer_chk
    import vecseq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               insn_boundary,
    input logic               ien,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_ready,
    input logic               busy,
    input logic               pc_load,
    input logic [NUM_IRQ-1:0] irq_ack
);
    // R1
    table_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr < ADDR_W'(2 * (NUM_IRQ + 1))));
    // R5
    no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(insn_boundary && ien)) |=> (!busy && !mem_req));
    // R6
    ien_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && insn_boundary && ien && (|irq_req)) |=> (!ien && busy));
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    // R8
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);
    // R8
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));
    // R8
    ack_with_load_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |-> pc_load);
endmodule

bind vector_sequencer vector_sequencer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_req       (irq_req),
    .insn_boundary (insn_boundary),
    .ien           (ien),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ready     (mem_ready),
    .busy          (busy),
    .pc_load       (pc_load),
    .irq_ack       (irq_ack)
);

// File: tb/tb_vector_sequencer.sv
`timescale 1ns/1ps
module tb_vector_sequencer;
    import vecseq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic insn_boundary = 1'b0;
    logic ien_set = 1'b0;
    logic ien_clr = 1'b0;
    logic ien, mem_req, mem_ready, busy, pc_load;
    logic [ADDR_W-1:0] mem_addr, pc_value;
    logic [DATA_W-1:0] mem_rdata;
    logic [NUM_IRQ-1:0] irq_ack;

    int n_chk = 0;
    int n_bad = 0;
    int wait_cfg = 0;
    int wcnt;

    always #5 clk = ~clk;

    vector_sequencer dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .insn_boundary(insn_boundary),
        .ien_set(ien_set), .ien_clr(ien_clr), .ien(ien),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .pc_load(pc_load),
        .pc_value(pc_value), .irq_ack(irq_ack)
    );

    // table contents: even word carries junk in its upper byte
    function automatic logic [DATA_W-1:0] tbl_word(input logic [ADDR_W-1:0] a);
        int k;
        k = int'(a >> 1);
        if (a >= 16) return 16'hDEAD;
        if (a[0] == 1'b0) return 16'hC300 | 16'(8'h40 + k);
        return 16'(16'h1111 * k + 16'h0123);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_target(input int k);
        return {8'(8'h40 + k), 16'(16'h1111 * k + 16'h0123)};
    endfunction

    assign mem_rdata = tbl_word(mem_addr);
    assign mem_ready = mem_req && (wcnt == wait_cfg);

    always_ff @(posedge clk) begin
        if (rst || !mem_req || mem_ready) wcnt <= 0;
        else                              wcnt <= wcnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // count falling edges until pc_load
    task automatic wait_load(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!pc_load && cnt < 60);
    endtask

    task automatic enable_ien();
        @(negedge clk); ien_set = 1'b1;
        @(negedge clk); ien_set = 1'b0;
    endtask

    // raise mask, take at a boundary, verify target, timing, ack, enable
    task automatic service(input logic [NUM_IRQ-1:0] mask, input int w);
        int cnt, win;
        win = 0;
        for (int i = NUM_IRQ; i >= 1; i--) if (mask[i-1]) win = i;
        wait_cfg = w;
        enable_ien();
        irq_req = mask;
        insn_boundary = 1'b1;
        @(posedge clk); #1;
        insn_boundary = 1'b0;
        @(negedge clk);
        check(ien == 1'b0, "R6 ien cleared on take", 32'(ien), 0);
        cnt = 1;
        while (!pc_load && cnt < 60) begin
            @(negedge clk); cnt++;
        end
        check(cnt == 2 * w + 3, "R7 load latency", cnt, 2 * w + 3);
        check(pc_value == exp_target(win), "R3 R4 target", pc_value, exp_target(win));
        check(irq_ack == NUM_IRQ'(1 << (win - 1)), "R4 R8 ack", 32'(irq_ack),
              32'(1 << (win - 1)));
        irq_req = '0;
        @(negedge clk);
        check(!pc_load && irq_ack == '0 && !busy, "R8 pulse ends", {pc_load, busy, irq_ack}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        wait_cfg = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy && mem_req && mem_addr == 0 && !pc_load && irq_ack == '0 && !ien,
              "R1 reset state", {busy, mem_req, pc_load, ien, irq_ack}, 32'h600);
        rst = 1'b0;
        // R2 boot fetch of index 0: 2w+2 cycles after release
        wait_load(cnt);
        check(cnt == 4, "R2 boot latency", cnt, 4);
        check(pc_value == exp_target(0), "R2 boot target", pc_value, exp_target(0));
        check(irq_ack == '0, "R2 no ack on boot", 32'(irq_ack), 0);
        @(negedge clk);
        check(!busy && !ien, "R2 idle after boot", {busy, ien}, 0);

        // R5 enable low: boundary with requests ignored
        irq_req = 7'h7F; insn_boundary = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!busy && !mem_req, "R5 ignored while ien low", {busy, mem_req}, 0);
        end
        // R5 enable high but no boundary
        insn_boundary = 1'b0;
        enable_ien();
        repeat (5) begin
            @(negedge clk);
            check(!busy && !mem_req, "R5 ignored without boundary", {busy, mem_req}, 0);
        end
        // R6 clear wins over set, then boundary is ignored
        ien_set = 1'b1; ien_clr = 1'b1;
        @(negedge clk);
        ien_set = 1'b0; ien_clr = 1'b0;
        check(!ien, "R6 clear wins", 32'(ien), 0);
        insn_boundary = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!busy, "R6 R5 no take after clear", 32'(busy), 0);
        end
        insn_boundary = 1'b0;
        irq_req = '0;

        // R3 R7 each line alone, wait states 0..3
        for (int n = 1; n <= NUM_IRQ; n++)
            for (int w = 0; w <= 3; w++)
                service(NUM_IRQ'(1 << (n - 1)), w);

        // R4 every request combination
        for (int m = 1; m < (1 << NUM_IRQ); m++)
            service(NUM_IRQ'(m), m % 3);

        finish_run();
    end
endmodule